// File: doc/BRIEF.md
# Video Compare Predicate Unit

This unit evaluates one integer condition between two sub-word video operands and turns that single result into writes for a small predicate register file. The operands arrive already extracted and aligned to the low bits of an `OPW`-bit field. Two signedness flags choose how they are read. The compare is signed as soon as either flag is set.

The compare result is merged with an incoming source predicate through a selectable AND, OR or XOR and written to the primary destination. The inverted compare result goes through the same merge and is written to an optional secondary destination. The predicate file has `2**PIDX_W` indices. The highest index is a constant-true entry that cannot be written. A primary destination that names it is flagged as an error, and nothing is written in that case.

All results are registered, so the write enables, write data and error flag appear one clock after a valid request. An idle cycle produces no writes.

Top module: `vcmp_pred_unit`

## Requirements
- R1: The compare treats both operands as two's-complement `OPW`-bit values when `sgn_a` or `sgn_b` is 1, and as unsigned values when both are 0.
- R2: `cond_sel` is a mask over the three outcomes: bit 0 selects less-than, bit 1 equal, bit 2 greater-than. This gives 0 = never, 1 = LT, 2 = EQ, 3 = LE, 4 = GT, 5 = NE, 6 = GE, 7 = always.
- R3: For a valid request with `pri_idx` not equal to the constant index, `wr_en[pri_idx]` is 1 and `wr_data[pri_idx]` equals (condition result) merged with `src_pred`.
- R4: The secondary value is (NOT condition result) merged with `src_pred` using the same merge as the primary. It is written at `sec_idx`.
- R5: `comb_sel` picks the merge: 0 = AND, 1 = OR, 2 = XOR. The value 3 behaves as AND.
- R6: A `sec_idx` equal to the constant index (all ones, 7 by default) produces no secondary write.
- R7: A `pri_idx` equal to the constant index raises `pri_err` and suppresses every write of that request, the secondary write included.
- R8: When `sec_idx` equals `pri_idx`, only the primary value is written at that index.
- R9: Outputs follow a valid request by exactly one clock. A cycle with `in_valid` low yields all enables 0 and `pri_err` 0 one clock later.
- R10: While `rst_n` is low at a clock edge, all outputs are cleared to 0.
- R11: Every `wr_data` bit whose `wr_en` bit is 0 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request present this cycle |
| opnd_a | input | OPW (16) | First extracted operand |
| opnd_b | input | OPW (16) | Second extracted operand |
| sgn_a | input | 1 | First operand marked signed |
| sgn_b | input | 1 | Second operand marked signed |
| cond_sel | input | 3 | Condition outcome mask |
| src_pred | input | 1 | Source predicate value |
| comb_sel | input | 2 | Merge selector |
| pri_idx | input | PIDX_W (3) | Primary destination index |
| sec_idx | input | PIDX_W (3) | Secondary destination index |
| wr_en | output | 2**PIDX_W-1 (7) | Per-entry write enable |
| wr_data | output | 2**PIDX_W-1 (7) | Per-entry write data |
| pri_err | output | 1 | Primary destination was the constant index |

## Verification
The assertions assume that request fields carry no X or Z while `in_valid` is high, and that reset is applied before the first request. They also assume that the register file honours `wr_en` and reads the constant index as true, so its contents are never checked here. The bench drives every field from fully defined loop counters and holds reset for several cycles before the first vector. With a 4-bit operand build, every operand pair is swept under every signedness pair and every condition. A second sweep covers every merge selector, source value and destination pair, including the constant index on both destinations.

// File: rtl/vcmp_pkg.sv
// Package: vcmp_pkg
// Shared encodings for the video compare predicate unit.
// Assumes the condition selector is a 3-bit outcome mask and the merge selector is 2 bits.
package vcmp_pkg;

    // Condition selector: bit0 = LT, bit1 = EQ, bit2 = GT.
    typedef enum logic [2:0] {
        COND_NEVER = 3'd0,
        COND_LT    = 3'd1,
        COND_EQ    = 3'd2,
        COND_LE    = 3'd3,
        COND_GT    = 3'd4,
        COND_NE    = 3'd5,
        COND_GE    = 3'd6,
        COND_ALWAYS = 3'd7
    } cond_e;

    // Merge selector; the spare code behaves as AND.
    typedef enum logic [1:0] {
        MRG_AND   = 2'd0,
        MRG_OR    = 2'd1,
        MRG_XOR   = 2'd2,
        MRG_SPARE = 2'd3
    } merge_e;

    // Outcome of the magnitude compare.
    typedef struct packed {
        logic gt;
        logic eq;
        logic lt;
    } outcome_t;

endpackage

// File: rtl/vcmp_magcmp.sv
// Module: vcmp_magcmp
// Three-way compare of two OPW-bit operands, unsigned or two's-complement.
// Assumes OPW >= 2. Signed order is obtained by flipping both sign bits and
// then comparing unsigned, so one comparator serves both modes.
module vcmp_magcmp #(
    parameter int OPW = 16
) (
    input  logic [OPW-1:0]       opa,
    input  logic [OPW-1:0]       opb,
    input  logic                 as_signed,
    output vcmp_pkg::outcome_t   res
);
    localparam int LOW_W = OPW - 1;

    logic [OPW-1:0] key_a;
    logic [OPW-1:0] key_b;

    // Bias both operands so that unsigned order matches the chosen order.
    always_comb begin
        key_a = {opa[OPW-1] ^ as_signed, opa[LOW_W-1:0]};
        key_b = {opb[OPW-1] ^ as_signed, opb[LOW_W-1:0]};
    end

    // Derive the three mutually exclusive outcomes.
    always_comb begin
        res.lt = key_a < key_b;
        res.eq = key_a == key_b;
        res.gt = !(key_a < key_b) && !(key_a == key_b);
    end

    // R1: exactly one outcome holds for any defined operand pair.
    always_comb begin
        if (!$isunknown({opa, opb, as_signed})) begin
            a_one_outcome_r1: assert ($onehot({res.gt, res.eq, res.lt}))
                else $error("compare outcome not one-hot");
        end
    end

endmodule

// File: rtl/vcmp_merge.sv
// Module: vcmp_merge
// Applies the condition mask to a compare outcome and merges the chosen
// polarity of the result with the source predicate.
// Assumes INVERT is 0 (primary lane) or 1 (secondary lane).
module vcmp_merge #(
    parameter bit INVERT = 1'b0
) (
    input  logic               [2:0] cond_sel,
    input  vcmp_pkg::outcome_t       outc,
    input  logic               [1:0] comb_sel,
    input  logic                     src_pred,
    output logic                     pbit
);
    import vcmp_pkg::*;

    logic hit;
    logic lane;

    // Select the outcomes enabled by the condition mask.
    always_comb begin
        hit = (cond_sel[0] & outc.lt) | (cond_sel[1] & outc.eq) | (cond_sel[2] & outc.gt);
    end

    // Pick the lane polarity at elaboration time.
    generate
        if (INVERT) begin : g_neg
            always_comb lane = ~hit;
        end else begin : g_pos
            always_comb lane = hit;
        end
    endgenerate

    // Merge the lane value with the source predicate.
    always_comb begin
        case (merge_e'(comb_sel))
            MRG_OR:  pbit = lane | src_pred;
            MRG_XOR: pbit = lane ^ src_pred;
            default: pbit = lane & src_pred;
        endcase
    end

endmodule

// File: rtl/vcmp_wrmap.sv
// Module: vcmp_wrmap
// Maps the primary and secondary predicate values onto per-entry write
// enables and data for a file whose top index is constant true.
// Assumes indices are PIDX_W bits wide. On a collision the primary wins.
// A primary aimed at the constant index blocks every write.
module vcmp_wrmap #(
    parameter int PIDX_W = 3
) (
    input  logic              valid,
    input  logic [PIDX_W-1:0] pri_idx,
    input  logic [PIDX_W-1:0] sec_idx,
    input  logic              pri_bit,
    input  logic              sec_bit,
    output logic [(1<<PIDX_W)-2:0] en,
    output logic [(1<<PIDX_W)-2:0] data,
    output logic              err
);
    localparam int NPRED = 1 << PIDX_W;
    localparam int NWR   = NPRED - 1;
    localparam logic [PIDX_W-1:0] CONST_IDX = PIDX_W'(NPRED - 1);

    // Flag a primary destination that names the constant entry.
    always_comb begin
        err = valid && (pri_idx == CONST_IDX);
    end

    // Decode each writable entry; the primary takes precedence.
    generate
        for (genvar i = 0; i < NWR; i++) begin : g_ent
            logic sel_p;
            logic sel_s;
            always_comb begin
                sel_p   = (pri_idx == PIDX_W'(i));
                sel_s   = (sec_idx == PIDX_W'(i));
                en[i]   = valid && !err && (sel_p || sel_s);
                data[i] = en[i] && (sel_p ? pri_bit : sec_bit);
            end
        end
    endgenerate

endmodule

// File: rtl/vcmp_pred_unit.sv
// Module: vcmp_pred_unit
// Video compare predicate unit. It compares two pre-extracted operands,
// applies a condition mask and merges the result, and its inverse, with a
// source predicate. The outcome is registered as write enables and data for
// the predicate file.
// Assumes operand extraction is done upstream and that the file reads its top
// index as constant true. Latency is one clock; reset is synchronous, active low.
module vcmp_pred_unit #(
    parameter int OPW    = 16,
    parameter int PIDX_W = 3
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [OPW-1:0]           opnd_a,
    input  logic [OPW-1:0]           opnd_b,
    input  logic                     sgn_a,
    input  logic                     sgn_b,
    input  logic [2:0]               cond_sel,
    input  logic                     src_pred,
    input  logic [1:0]               comb_sel,
    input  logic [PIDX_W-1:0]        pri_idx,
    input  logic [PIDX_W-1:0]        sec_idx,
    output logic [(1<<PIDX_W)-2:0]   wr_en,
    output logic [(1<<PIDX_W)-2:0]   wr_data,
    output logic                     pri_err
);
    import vcmp_pkg::*;

    localparam int NPRED = 1 << PIDX_W;
    localparam int NWR   = NPRED - 1;
    localparam logic [PIDX_W-1:0] CONST_IDX = PIDX_W'(NPRED - 1);

    outcome_t          outc;
    logic              cmp_signed;
    logic [1:0]        lane_bit;
    logic [NWR-1:0]    nx_en;
    logic [NWR-1:0]    nx_data;
    logic              nx_err;

    // Signed compare as soon as either operand is marked signed.
    always_comb begin
        cmp_signed = sgn_a | sgn_b;
    end

    vcmp_magcmp #(.OPW(OPW)) u_cmp (
        .opa       (opnd_a),
        .opb       (opnd_b),
        .as_signed (cmp_signed),
        .res       (outc)
    );

    // Lane 0 carries the primary value, lane 1 the inverted secondary value.
    generate
        for (genvar k = 0; k < 2; k++) begin : g_lane
            vcmp_merge #(.INVERT(k == 1)) u_mrg (
                .cond_sel (cond_sel),
                .outc     (outc),
                .comb_sel (comb_sel),
                .src_pred (src_pred),
                .pbit     (lane_bit[k])
            );
        end
    endgenerate

    vcmp_wrmap #(.PIDX_W(PIDX_W)) u_map (
        .valid   (in_valid),
        .pri_idx (pri_idx),
        .sec_idx (sec_idx),
        .pri_bit (lane_bit[0]),
        .sec_bit (lane_bit[1]),
        .en      (nx_en),
        .data    (nx_data),
        .err     (nx_err)
    );

    // Register the write strobes, data and error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= '0;
            wr_data <= '0;
            pri_err <= 1'b0;
        end else begin
            wr_en   <= nx_en;
            wr_data <= nx_data;
            pri_err <= nx_err;
        end
    end

    // R7: an error never comes with a write.
    p_err_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pri_err |-> (wr_en == '0));

    // R7: a constant primary destination raises the error one clock later.
    p_err_on_const_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pri_idx == CONST_IDX) |=> pri_err);

    // R9: idle cycles leave the outputs quiet.
    p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (wr_en == '0 && !pri_err));

    // R3: a legal primary destination always produces a write.
    p_pri_written_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pri_idx != CONST_IDX) |=> ($countones(wr_en) >= 1 && !pri_err));

    // R4: distinct legal destinations produce exactly two writes.
    p_two_writes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && pri_idx != CONST_IDX && sec_idx != CONST_IDX && sec_idx != pri_idx)
        |=> ($countones(wr_en) == 2));

    // R8: at most two entries are written per request.
    p_at_most_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_en) <= 2);

    // R11: data bits outside the enabled entries are zero.
    p_data_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_data & ~wr_en) == '0);

endmodule

// File: tb/sim_vcmp_pred_unit.sv
`timescale 1ns/1ps
module sim_vcmp_pred_unit;
    localparam int OPW = 4;
    localparam int PW  = 3;
    localparam int NWR = (1 << PW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [OPW-1:0] opnd_a = '0;
    logic [OPW-1:0] opnd_b = '0;
    logic sgn_a = 1'b0, sgn_b = 1'b0;
    logic [2:0] cond_sel = '0;
    logic src_pred = 1'b0;
    logic [1:0] comb_sel = '0;
    logic [PW-1:0] pri_idx = '0;
    logic [PW-1:0] sec_idx = '0;
    logic [NWR-1:0] wr_en;
    logic [NWR-1:0] wr_data;
    logic pri_err;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    vcmp_pred_unit #(.OPW(OPW), .PIDX_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .opnd_a(opnd_a), .opnd_b(opnd_b), .sgn_a(sgn_a), .sgn_b(sgn_b),
        .cond_sel(cond_sel), .src_pred(src_pred), .comb_sel(comb_sel),
        .pri_idx(pri_idx), .sec_idx(sec_idx),
        .wr_en(wr_en), .wr_data(wr_data), .pri_err(pri_err)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int sval(input int v, input bit sg);
        return (sg && v >= (1 << (OPW-1))) ? v - (1 << OPW) : v;
    endfunction

    function automatic bit merge(input bit x, input bit s, input int c);
        if (c == 1) return x | s;
        if (c == 2) return x ^ s;
        return x & s;
    endfunction

    // Apply one request and compare the registered outputs one clock later.
    task automatic run(input int a, input int b, input int sa, input int sb, input int c,
                       input int src, input int cm, input int p, input int s, input string tag);
        int va, vb, ee, ed, er;
        bit lt, eq, gt, hit, pv, sv;
        @(negedge clk);
        in_valid = 1'b1;
        opnd_a = OPW'(a); opnd_b = OPW'(b);
        sgn_a = sa[0]; sgn_b = sb[0];
        cond_sel = 3'(c); src_pred = src[0]; comb_sel = 2'(cm);
        pri_idx = PW'(p); sec_idx = PW'(s);
        va = sval(a, sa[0] | sb[0]);
        vb = sval(b, sa[0] | sb[0]);
        lt = va < vb; eq = va == vb; gt = va > vb;
        hit = (c[0] && lt) || (c[1] && eq) || (c[2] && gt);
        pv = merge(hit, src[0], cm);
        sv = merge(!hit, src[0], cm);
        ee = 0; ed = 0; er = 0;
        if (p == NWR) er = 1;
        else begin
            ee = 1 << p; ed = pv ? (1 << p) : 0;
            if (s != NWR && s != p) begin
                ee |= 1 << s;
                if (sv) ed |= 1 << s;
            end
        end
        @(posedge clk);
        #1;
        check(int'(wr_en) == ee, {tag, " wr_en"}, int'(wr_en), ee);
        check(int'(wr_data) == ed, {tag, " wr_data"}, int'(wr_data), ed);
        check(int'(pri_err) == er, {tag, " pri_err"}, int'(pri_err), er);
    endtask

    initial begin
        // R10: reset clears outputs even with a request held valid.
        in_valid = 1'b1; pri_idx = '0; sec_idx = 3'd1; cond_sel = 3'd7; src_pred = 1'b1;
        repeat (4) @(posedge clk);
        #1;
        check(wr_en == '0 && wr_data == '0 && !pri_err, "R10 reset state",
              int'({pri_err, wr_en, wr_data}), 0);
        @(negedge clk);
        rst_n = 1'b1;
        in_valid = 1'b0;

        // R1 R2 R3 R4: every operand pair, signedness pair and condition.
        for (int a = 0; a < 16; a++)
            for (int b = 0; b < 16; b++)
                for (int sg = 0; sg < 4; sg++)
                    for (int c = 0; c < 8; c++)
                        run(a, b, sg & 1, sg >> 1, c, (a + c) & 1, (a ^ b ^ c) % 3,
                            (a + c) % 7, (b + sg + 3) % 7, "R1 R2 R3 R4 sweep");

        // R4 R5 R6 R7 R8 R11: every merge, source value and destination pair.
        for (int cm = 0; cm < 4; cm++)
            for (int src = 0; src < 2; src++)
                for (int p = 0; p < 8; p++)
                    for (int s = 0; s < 8; s++)
                        for (int c = 0; c < 8; c += 3)
                            run(9, 3, c & 1, 0, c, src, cm, p, s,
                                "R4 R5 R6 R7 R8 R11 routing");

        // R9: an idle cycle after a write yields no enables and no error.
        run(2, 2, 0, 0, 2, 1, 0, 3, 4, "R9 before idle");
        @(negedge clk);
        in_valid = 1'b0; pri_idx = 3'd7;
        @(posedge clk);
        #1;
        check(wr_en == '0 && !pri_err, "R9 idle", int'({pri_err, wr_en}), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule